// File: doc/BRIEF.md
# Indirect Register-to-Bus Transaction Bridge

This block gives a host that only issues 64-bit register accesses a way to run single read or write transactions on a 32-bit on-chip bus. The host sees four 64-bit registers. It loads an outgoing data word into one of them. It then writes a command word that carries the target address, a byte count and a direction bit. That command write immediately launches one downstream transaction.

When the transaction ends, the outcome is packed into a status word. For reads, this word holds the returned bytes. The host collects it with one read, and that read also empties the status register. A failed read still reports completion, but its data field is filled with ones. A write always reports bare completion.

The downstream side is a plain request/acknowledge/error master. It keeps its request asserted until the target answers. A bounded wait counter converts a target that never answers into an error. While a transaction is in flight the bridge reports busy, and further command writes are dropped.

Top module: `ibb_bridge`

## Requirements
- R1: Host byte address bits [4:3] alone choose the register: 0 command, 1 reset, 2 status, 3 data; other address bits are ignored.
- R2: A command write while idle raises `ds_req` on the next cycle. It presents `ds_addr` = command bits 31:0, `ds_size` = command bits 59:56, and `ds_we` = NOT command bit 48 (bit 48 set means read). These values stay stable until the transaction ends.
- R3: A write transaction drives the data register value on `ds_wdata`, with the first (most significant) byte on bits 31:24.
- R4: A read that ends with `ds_ack` and no `ds_err` loads status with bit 11 set and the returned 32-bit word in bits 57:26; all other bits are zero.
- R5: A read that ends with `ds_err`, or by timeout, loads status with bit 11 set and ones in bits 57:26.
- R6: A write transaction, successful or not, loads status with only bit 11 set.
- R7: A status read returns the current status value and leaves the register at zero.
- R8: A data register write stores host bits 63:32. A data register read returns the stored value in bits 63:32, with zeros below.
- R9: Reads of the command and reset registers return zero. Writes to the reset and status registers change nothing.
- R10: `busy` is high from the cycle after an accepted command write until the transaction ends. A command write while busy is ignored.
- R11: If no `ds_ack`/`ds_err` arrives, `ds_req` stays high for exactly TMO_CYCLES cycles. The transaction then ends as an error.
- R12: After reset, `busy` and `ds_req` are low, and the status and data registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | HA_W | Host byte address |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Read data, valid the cycle after `host_rd` |
| busy | output | 1 | Transaction in flight |
| ds_req | output | 1 | Downstream request |
| ds_we | output | 1 | Downstream direction, 1 = write |
| ds_addr | output | 32 | Downstream address |
| ds_size | output | 4 | Downstream byte count |
| ds_wdata | output | 32 | Downstream write data |
| ds_ack | input | 1 | Downstream success response |
| ds_err | input | 1 | Downstream error response (wins over ack) |
| ds_rdata | input | 32 | Downstream read data |

## Verification
On every cycle, assertions check several things:
- Requests only arise from a command write.
- Address and direction hold while a request is outstanding.
- The request never outlives `busy`.
- The wait counter stays bounded.
- Each completion lands the right status shape, and a status read empties the register.

Only the bench scenarios can show certain other behaviour:
- The exact bit placement of read data and the error fill.
- The byte ordering of write data.
- That ignored writes leave state untouched.
- The exact length of a timed-out request.

// File: rtl/ibb_pkg.sv
package ibb_pkg;
    localparam int DS_DW      = 32;
    localparam int HOST_DW    = 64;
    localparam int DONE_POS   = 11;
    localparam int RDF_LSB    = 26;
    localparam int RD_POS     = 48;
    localparam int SZ_LSB     = 56;
    localparam int SZ_W       = 4;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_RST  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_DATA = 2'd3
    } sel_e;

    typedef struct packed {
        logic             rd;
        logic [SZ_W-1:0]  size;
        logic [DS_DW-1:0] addr;
    } cmd_t;

    typedef struct packed {
        logic             done;
        logic             err;
        logic             rd;
        logic [DS_DW-1:0] rdata;
    } resp_t;
endpackage

// File: rtl/ibb_cmd_decode.sv
module ibb_cmd_decode
    import ibb_pkg::*;
(
    input  logic [HOST_DW-1:0] word,
    output cmd_t               cmd
);
    logic unused_bits;
    assign unused_bits = ^{word[63:60], word[55:49], word[47:32]};

    always_comb begin
        cmd.rd   = word[RD_POS];
        cmd.size = word[SZ_LSB +: SZ_W];
        cmd.addr = word[DS_DW-1:0];
    end
endmodule

// File: rtl/ibb_status_pack.sv
module ibb_status_pack
    import ibb_pkg::*;
(
    input  resp_t              resp,
    output logic [HOST_DW-1:0] word
);
    logic unused_done;
    assign unused_done = resp.done;

    always_comb begin
        word           = '0;
        word[DONE_POS] = 1'b1;
        if (resp.rd)
            word[RDF_LSB +: DS_DW] = resp.err ? {DS_DW{1'b1}} : resp.rdata;
    end
endmodule

// File: rtl/ibb_xfer.sv
module ibb_xfer
    import ibb_pkg::*;
#(
    parameter int TMO_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  cmd_t             cmd,
    input  logic [DS_DW-1:0] wdata,
    output logic             busy,
    output logic             ds_req,
    output logic             ds_we,
    output logic [DS_DW-1:0] ds_addr,
    output logic [SZ_W-1:0]  ds_size,
    output logic [DS_DW-1:0] ds_wdata,
    input  logic             ds_ack,
    input  logic             ds_err,
    input  logic [DS_DW-1:0] ds_rdata,
    output resp_t            resp
);
    localparam int CW = (TMO_CYCLES > 2) ? $clog2(TMO_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(TMO_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        cmd_t             cmd;
        logic [DS_DW-1:0] wdata;
        logic [CW-1:0]    cnt;
    } xst_t;

    xst_t q, d;

    always_comb begin
        d    = q;
        resp = '0;
        if (!q.busy) begin
            if (start) begin
                d.busy  = 1'b1;
                d.cmd   = cmd;
                d.wdata = wdata;
                d.cnt   = '0;
            end
        end else if (ds_ack || ds_err) begin
            d.busy     = 1'b0;
            resp.done  = 1'b1;
            resp.err   = ds_err;
            resp.rd    = q.cmd.rd;
            resp.rdata = ds_rdata;
        end else if (q.cnt == CNT_LAST) begin
            d.busy     = 1'b0;
            resp.done  = 1'b1;
            resp.err   = 1'b1;
            resp.rd    = q.cmd.rd;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = q.busy;
    assign ds_req   = q.busy;
    assign ds_we    = ~q.cmd.rd;
    assign ds_addr  = q.cmd.addr;
    assign ds_size  = q.cmd.size;
    assign ds_wdata = q.wdata;

    assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.cnt <= CNT_LAST));

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_req && !ds_ack && !ds_err) |=> ($stable(ds_addr) && $stable(ds_we) && $stable(ds_size)));

    assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && start) |=> $stable(ds_addr));
endmodule

// File: rtl/ibb_bridge.sv
module ibb_bridge
    import ibb_pkg::*;
#(
    parameter int HA_W       = 8,
    parameter int TMO_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HA_W-1:0]    host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    output logic               busy,
    output logic               ds_req,
    output logic               ds_we,
    output logic [DS_DW-1:0]   ds_addr,
    output logic [SZ_W-1:0]    ds_size,
    output logic [DS_DW-1:0]   ds_wdata,
    input  logic               ds_ack,
    input  logic               ds_err,
    input  logic [DS_DW-1:0]   ds_rdata
);
    typedef struct packed {
        logic [DS_DW-1:0]   data;
        logic [HOST_DW-1:0] status;
        logic [HOST_DW-1:0] rdata;
    } tst_t;

    tst_t q, d;
    sel_e sel;
    cmd_t cmd;
    resp_t resp;
    logic [HOST_DW-1:0] packed_status;
    logic start;

    logic unused_addr;
    if (HA_W > 5) begin : g_hi
        assign unused_addr = ^{host_addr[HA_W-1:5], host_addr[2:0]};
    end else begin : g_lo
        assign unused_addr = ^host_addr[2:0];
    end

    assign sel   = sel_e'(host_addr[4:3]);
    assign start = host_wr && (sel == SEL_CMD);

    ibb_cmd_decode u_dec (
        .word (host_wdata),
        .cmd  (cmd)
    );

    ibb_xfer #(.TMO_CYCLES(TMO_CYCLES)) u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmd      (cmd),
        .wdata    (q.data),
        .busy     (busy),
        .ds_req   (ds_req),
        .ds_we    (ds_we),
        .ds_addr  (ds_addr),
        .ds_size  (ds_size),
        .ds_wdata (ds_wdata),
        .ds_ack   (ds_ack),
        .ds_err   (ds_err),
        .ds_rdata (ds_rdata),
        .resp     (resp)
    );

    ibb_status_pack u_pack (
        .resp (resp),
        .word (packed_status)
    );

    always_comb begin
        d = q;
        if (host_wr && sel == SEL_DATA)
            d.data = host_wdata[HOST_DW-1:DS_DW];
        if (host_rd) begin
            case (sel)
                SEL_STAT: begin
                    d.rdata  = q.status;
                    d.status = '0;
                end
                SEL_DATA: d.rdata = {q.data, {DS_DW{1'b0}}};
                default:  d.rdata = '0;
            endcase
        end
        if (resp.done)
            d.status = packed_status;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign host_rdata = q.rdata;

    assert_req_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ds_req) |-> ($past(host_wr) && $past(host_addr[4:3]) == 2'd0));

    assert_req_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ds_req |-> busy);

    assert_stat_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr[4:3] == 2'd2 && !resp.done) |=> (q.status == '0));

    assert_wr_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp.done && !resp.rd) |=> (q.status == 64'h800));

    assert_err_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp.done && resp.rd && resp.err) |=> (q.status[57:26] == 32'hFFFF_FFFF && q.status[11]));

    assert_status_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.status != '0) |-> (q.status[11] && q.status[63:58] == '0 && q.status[25:12] == '0 && q.status[10:0] == '0));
endmodule

// File: tb/sim_ibb_bridge.sv
module sim_ibb_bridge;
    localparam int TMO = 12;
    localparam logic [7:0] A_CMD = 8'h00, A_RST = 8'h08, A_STAT = 8'h10, A_DATA = 8'h18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_addr = '0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic busy, ds_req, ds_we;
    logic [31:0] ds_addr, ds_wdata;
    logic [3:0] ds_size;
    logic ds_ack = 1'b0, ds_err = 1'b0;
    logic [31:0] ds_rdata = '0;

    always #5 clk = ~clk;

    ibb_bridge #(.HA_W(8), .TMO_CYCLES(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .busy(busy), .ds_req(ds_req), .ds_we(ds_we), .ds_addr(ds_addr),
        .ds_size(ds_size), .ds_wdata(ds_wdata), .ds_ack(ds_ack), .ds_err(ds_err),
        .ds_rdata(ds_rdata)
    );

    int nchk = 0, nerr = 0;
    int cyc = 0;
    bit finished = 0;

    // downstream responder and monitor
    int resp_lat = 0;
    bit resp_err = 0, resp_hang = 0;
    logic [31:0] resp_data = '0;
    int rcnt = 0;
    int req_cycles = 0;
    int txn_count = 0;
    logic prev_req = 1'b0;

    always @(negedge clk) begin
        if (ds_req) begin
            req_cycles++;
            if (!prev_req) txn_count++;
            if (!resp_hang && rcnt == resp_lat) begin
                ds_ack   = !resp_err;
                ds_err   = resp_err;
                ds_rdata = resp_data;
            end else begin
                ds_ack = 1'b0;
                ds_err = 1'b0;
                rcnt++;
            end
        end else begin
            ds_ack = 1'b0;
            ds_err = 1'b0;
            rcnt   = 0;
        end
        prev_req = ds_req;
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            nchk++; nerr++;
            $display("FAIL watchdog act=%0d exp=<100000", cyc);
            summary();
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(logic [7:0] a, logic [63:0] v);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(logic [7:0] a, output logic [63:0] v);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        v = host_rdata;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic logic [63:0] exp_stat(bit rd, bit err, logic [31:0] rdat);
        logic [63:0] s = 64'h800;
        if (rd) s[57:26] = err ? 32'hFFFF_FFFF : rdat;
        return s;
    endfunction

    function automatic logic [63:0] mk_cmd(bit rd, logic [3:0] sz, logic [31:0] a);
        return ({4'h0, sz, 56'h0}) | (rd ? 64'h1 << 48 : 64'h0) | {32'h0, a};
    endfunction

    typedef struct packed {
        logic        rd;
        logic [3:0]  size;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] rdat;
        logic [3:0]  lat;
        logic        err;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 4'd4, 32'hD001_0060, 32'hA1B2_C3D4, 32'h0000_0000, 4'd0, 1'b0},
        '{1'b1, 4'd4, 32'hE001_1234, 32'h0000_0000, 32'h89AB_CDEF, 4'd2, 1'b0},
        '{1'b1, 4'd1, 32'hF000_0010, 32'h0000_0000, 32'h1234_5678, 4'd1, 1'b1},
        '{1'b0, 4'd2, 32'h0000_0004, 32'h0F0F_1234, 32'h5555_5555, 4'd3, 1'b1},
        '{1'b1, 4'd1, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 4'd0, 1'b0},
        '{1'b1, 4'd4, 32'h0000_0100, 32'h0000_0000, 32'hFFFF_FFFE, 4'd4, 1'b0}
    };

    initial begin
        logic [63:0] v;
        logic [31:0] cap_addr, cap_wdata;
        logic [3:0] cap_size;
        logic cap_we;
        int base;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12 busy", {63'h0, busy}, 64'h0);
        chk("R12 ds_req", {63'h0, ds_req}, 64'h0);
        hread(A_STAT, v); chk("R12 status", v, 64'h0);
        hread(A_DATA, v); chk("R12 data", v, 64'h0);

        // vector table
        foreach (VECS[i]) begin
            vec_t t = VECS[i];
            resp_lat = t.lat; resp_err = t.err; resp_data = t.rdat; resp_hang = 0;
            hwrite(A_DATA, {t.wdata, 32'hDEAD_BEEF});
            base = req_cycles;
            hwrite(A_CMD, mk_cmd(t.rd, t.size, t.addr));
            chk("R10 busy set", {63'h0, busy}, 64'h1);
            cap_addr = ds_addr; cap_size = ds_size; cap_we = ds_we; cap_wdata = ds_wdata;
            chk("R2 addr", {32'h0, cap_addr}, {32'h0, t.addr});
            chk("R2 size", {60'h0, cap_size}, {60'h0, t.size});
            chk("R2 dir", {63'h0, cap_we}, {63'h0, ~t.rd});
            if (!t.rd) chk("R3 wdata", {32'h0, cap_wdata}, {32'h0, t.wdata});
            wait_idle();
            chk("R2 req length", 64'(req_cycles - base), 64'(t.lat + 1));
            hread(A_STAT, v);
            if (!t.rd)         chk("R6 write status", v, 64'h800);
            else if (t.err)    chk("R5 error fill", v, exp_stat(1, 1, t.rdat));
            else               chk("R4 read status", v, exp_stat(1, 0, t.rdat));
            hread(A_STAT, v); chk("R7 cleared", v, 64'h0);
        end

        // R8 data register
        hwrite(A_DATA, 64'h1357_9BDF_FFFF_FFFF);
        hread(A_DATA, v); chk("R8 data readback", v, 64'h1357_9BDF_0000_0000);
        // R1 alias through bit 5
        hread(8'h38, v); chk("R1 alias data", v, 64'h1357_9BDF_0000_0000);
        // R9 zero reads
        hread(A_CMD, v); chk("R9 cmd read", v, 64'h0);
        hread(A_RST, v); chk("R9 reset read", v, 64'h0);

        // R9 writes to status/reset ignored with status pending
        resp_lat = 0; resp_err = 0; resp_data = 32'hCAFE_0001;
        hwrite(A_CMD, mk_cmd(1, 4'd4, 32'h10));
        wait_idle();
        hwrite(A_STAT, 64'hFFFF_FFFF_FFFF_FFFF);
        hwrite(A_RST, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R9 no start from reset write", {63'h0, busy}, 64'h0);
        hread(A_DATA, v); chk("R9 data kept", v, 64'h1357_9BDF_0000_0000);
        hread(A_STAT, v); chk("R9 status kept", v, exp_stat(1, 0, 32'hCAFE_0001));

        // R10 command while busy ignored
        resp_lat = 6; resp_data = 32'h0BAD_F00D;
        base = txn_count;
        hwrite(A_CMD, mk_cmd(1, 4'd4, 32'hAAAA_0000));
        hwrite(A_CMD, mk_cmd(0, 4'd1, 32'hBBBB_0000));
        chk("R10 addr unchanged", {32'h0, ds_addr}, 64'hAAAA_0000);
        chk("R10 dir unchanged", {63'h0, ds_we}, 64'h0);
        wait_idle();
        repeat (3) @(negedge clk);
        chk("R10 one txn", 64'(txn_count - base), 64'd1);
        hread(A_STAT, v); chk("R10 status of first", v, exp_stat(1, 0, 32'h0BAD_F00D));

        // R11 timeout on read
        resp_hang = 1;
        base = req_cycles;
        hwrite(A_CMD, mk_cmd(1, 4'd4, 32'h0000_2000));
        wait_idle();
        chk("R11 req length", 64'(req_cycles - base), 64'(TMO));
        hread(A_STAT, v); chk("R11 timeout fill", v, exp_stat(1, 1, 32'h0));
        // R11 timeout on write
        hwrite(A_CMD, mk_cmd(0, 4'd4, 32'h0000_2004));
        wait_idle();
        hread(A_STAT, v); chk("R11 write timeout status", v, 64'h800);
        resp_hang = 0;

        if (!finished) begin
            finished = 1;
            summary();
        end
    end
endmodule